// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block supervises the start-up of one step-down switching channel. It runs on the system clock, and a one-cycle strobe marks each switching period. All timing inside the block is counted in those strobes. The inputs are already-synchronised comparator results: supply ready, enable rising past its upper threshold, enable falling past its lower threshold, overcurrent, and feedback above the power-good set level or below the power-good clear level. The block produces three outputs: a reference code for an external DAC, a driver-enable output for both gate drivers, and a power-good flag.

After a valid enable, the reference code ramps one step per switching period from zero to full scale, and then holds there while the channel regulates. An overcurrent turns the drivers off in the same cycle. The channel then stays down for a fixed number of switching periods and starts again from zero. Losing enable or supply readiness shuts the channel down at once. Power-good has set/clear hysteresis and reports only in the regulating phase.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While reset is held and just after it is released, `ref_code` is 0, `drv_en` is 0 and `pgood` is 0.
- R2: An internal enable level is set by an `en_hi` strobe and cleared by `en_lo`. `en_lo` wins when both are high. A start needs `por_ok` high and that level set. The ramp then begins at the next clock edge, with `drv_en` high and `ref_code` 0.
- R3: During the ramp, `ref_code` rises by exactly one on each edge where `sw_tick` is high. It does not change while `sw_tick` is low. It climbs to 2^REF_W-1 (2047 by default), and after 2^REF_W ticks in total it holds that value.
- R4: `drv_en` is high throughout the ramp and regulation phases.
- R5: While `en_lo` is high, `drv_en` is 0 in the same cycle and `ref_code` is 0 after the next edge. The channel stays off until a new `en_hi` strobe.
- R6: While `ocp_flag` is high, `drv_en` is 0 in the same cycle. On the next edge `ref_code` is 0 and the hiccup wait begins. The drivers stay off for HICCUP_TICKS ticks (2048 by default). One idle cycle follows, and then a new ramp starts from 0 if the channel is still enabled.
- R7: An `ocp_flag` pulse during the hiccup wait neither restarts nor extends the wait.
- R8: In regulation, `pgood` rises on the edge after `fb_hi` is seen. It then stays high while neither flag is asserted, and it falls only on the edge after `fb_lo` is seen.
- R9: `pgood` is 0 during reset, ramp and hiccup, whatever the feedback flags are.
- R10: When `por_ok` is low, `drv_en` is 0 in the same cycle and `ref_code` is 0 after the next edge. When `por_ok` returns while the enable level is still set, a new ramp starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_tick | input | 1 | One-cycle strobe per switching period |
| por_ok | input | 1 | Supply ready |
| en_hi | input | 1 | Enable rose above upper threshold |
| en_lo | input | 1 | Enable fell below lower threshold |
| ocp_flag | input | 1 | Overcurrent comparator level |
| fb_hi | input | 1 | Feedback at or above power-good set level |
| fb_lo | input | 1 | Feedback below power-good clear level |
| ref_code | output | REF_W | Soft-start reference code for the DAC |
| drv_en | output | 1 | Gate driver enable (both drivers) |
| pgood | output | 1 | Power-good flag |

## Verification
Some properties are checked every cycle. The drivers are off whenever overcurrent or the lower enable flag is present and throughout the hiccup wait. The reference only ever steps by one or returns to zero. Power-good never stands high unless the reference is at full scale, and it never rises without the set flag. The hiccup counter never moves backwards while it runs. Only the directed scenarios can show the exact lengths: 2048 ramp ticks, 2048 wait ticks, freezing while the tick is absent, the hysteresis hold in the band between thresholds, and the ignored overcurrent pulse mid-wait.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
   typedef enum logic [1:0] {
      SS_OFF    = 2'd0,
      SS_RAMP   = 2'd1,
      SS_REG    = 2'd2,
      SS_HICCUP = 2'd3
   } ss_state_t;
endpackage

// File: rtl/ss_enable_level.sv
module ss_enable_level (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic level_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     level_o <= 1'b0;
      else if (clr_i) level_o <= 1'b0;
      else if (set_i) level_o <= 1'b1;
   end

   // R2: clear wins over set
   a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !level_o);
endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
   parameter int REF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [REF_W-1:0] code_o,
   output logic             full_o
);
   localparam logic [REF_W-1:0] CODE_MAX = '1;

   logic [REF_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            code_q <= '0;
      else if (clear_i)                      code_q <= '0;
      else if (step_i && code_q != CODE_MAX) code_q <= code_q + 1'b1;
   end

   assign code_o = code_q;
   assign full_o = (code_q == CODE_MAX);

   // R3: code moves only by one step up or back to zero
   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != $past(code_q)) |-> (code_q == $past(code_q) + 1'b1 || code_q == '0));
endmodule

// File: rtl/ss_hiccup_timer.sv
module ss_hiccup_timer #(
   parameter int TICKS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && tick_i && (cnt_q == LAST);

   // R7: the wait counter never moves back while the wait runs
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && !$past(done_o)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/ss_pgood_hyst.sv
module ss_pgood_hyst #(
   parameter bit HYST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allow_i,
   input  logic above_i,
   input  logic below_i,
   output logic pg_o
);
   generate
      if (HYST) begin : g_hyst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pg_o <= 1'b0;
            else if (!allow_i) pg_o <= 1'b0;
            else if (below_i)  pg_o <= 1'b0;
            else if (above_i)  pg_o <= 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pg_o <= 1'b0;
            else        pg_o <= allow_i && above_i && !below_i;
         end
      end
   endgenerate

   // R8: power-good rises only after the set-level flag
   a_r8_rise_needs_above: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_o) |-> $past(above_i));
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq
   import ss_seq_pkg::*;
#(
   parameter int REF_W        = 11,
   parameter int HICCUP_TICKS = 2048,
   parameter bit PG_HYST      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_tick,
   input  logic             por_ok,
   input  logic             en_hi,
   input  logic             en_lo,
   input  logic             ocp_flag,
   input  logic             fb_hi,
   input  logic             fb_lo,
   output logic [REF_W-1:0] ref_code,
   output logic             drv_en,
   output logic             pgood
);
   localparam logic [REF_W-1:0] REF_FULL = '1;

   generate
      if (REF_W < 2 || REF_W > 24) begin : g_bad_ref_w
         $error("ss_hiccup_seq: REF_W out of range");
      end
      if (HICCUP_TICKS < 2) begin : g_bad_hiccup
         $error("ss_hiccup_seq: HICCUP_TICKS must be at least 2");
      end
   endgenerate

   ss_state_t state_q, state_d;
   logic      en_level, ramp_full, hic_done, off_req, running;

   ss_enable_level u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (en_hi),
      .clr_i  (en_lo),
      .level_o(en_level)
   );

   assign off_req = !por_ok || !en_level || en_lo;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SS_OFF:    if (!off_req)                   state_d = SS_RAMP;
         SS_RAMP:   if (off_req)                    state_d = SS_OFF;
                    else if (ocp_flag)              state_d = SS_HICCUP;
                    else if (sw_tick && ramp_full)  state_d = SS_REG;
         SS_REG:    if (off_req)                    state_d = SS_OFF;
                    else if (ocp_flag)              state_d = SS_HICCUP;
         SS_HICCUP: if (off_req || hic_done)        state_d = SS_OFF;
         default:                                   state_d = SS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SS_OFF;
      else        state_q <= state_d;
   end

   ss_ramp_gen #(.REF_W(REF_W)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(state_d == SS_OFF || state_d == SS_HICCUP),
      .step_i (state_q == SS_RAMP && sw_tick),
      .code_o (ref_code),
      .full_o (ramp_full)
   );

   ss_hiccup_timer #(.TICKS(HICCUP_TICKS)) u_hic (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (state_q == SS_HICCUP),
      .tick_i(sw_tick),
      .done_o(hic_done)
   );

   ss_pgood_hyst #(.HYST(PG_HYST)) u_pg (
      .clk    (clk),
      .rst_n  (rst_n),
      .allow_i(state_d == SS_REG),
      .above_i(fb_hi),
      .below_i(fb_lo),
      .pg_o   (pgood)
   );

   assign running = (state_q == SS_RAMP) || (state_q == SS_REG);
   assign drv_en  = running && !ocp_flag && !off_req;

   // R6: overcurrent removes drive in the same cycle
   a_r6_ocp_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_flag |-> !drv_en);
   // R6: no drive during the whole wait
   a_r6_hiccup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SS_HICCUP) |-> !drv_en);
   // R5: lower enable flag clears the reference by the next edge
   a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      en_lo |=> (ref_code == '0));
   // R9: power-good only with the reference at full scale
   a_r9_pgood_full: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (ref_code == REF_FULL));
   // R2: drive may start only with supply ready
   a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> por_ok);
endmodule

// File: tb/ss_hiccup_seq_tb.sv
module ss_hiccup_seq_tb;
   localparam int REF_W = 11;
   localparam int HIC   = 2048;

   logic clk = 1'b0;
   logic rst_n, sw_tick, por_ok, en_hi, en_lo, ocp_flag, fb_hi, fb_lo;
   logic [REF_W-1:0] ref_code;
   logic drv_en, pgood;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ss_hiccup_seq #(.REF_W(REF_W), .HICCUP_TICKS(HIC)) u_dut (
      .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .por_ok(por_ok),
      .en_hi(en_hi), .en_lo(en_lo), .ocp_flag(ocp_flag), .fb_hi(fb_hi),
      .fb_lo(fb_lo), .ref_code(ref_code), .drv_en(drv_en), .pgood(pgood)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_en_hi();
      en_hi = 1'b1; step(1); en_hi = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ref", ref_code, 0);
      chk("R1 drv", drv_en, 0);
      chk("R1 pgood", pgood, 0);
   endtask

   task automatic t_start_gate();
      por_ok = 1'b1; step(5);
      chk("R2 no enable no drive", drv_en, 0);
      por_ok = 1'b0; pulse_en_hi(); step(3);
      chk("R2 no por no drive", drv_en, 0);
      por_ok = 1'b1; step(1);
      chk("R2 ramp start drv", drv_en, 1);
      chk("R2 ramp start ref", ref_code, 0);
      step(10);
      chk("R3 ref after 10 ticks", ref_code, 10);
      chk("R4 drv during ramp", drv_en, 1);
      chk("R9 pgood low in ramp", pgood, 0);
   endtask

   task automatic t_tick_gate();
      sw_tick = 1'b0; step(5);
      chk("R3 frozen without tick", ref_code, 10);
      sw_tick = 1'b1;
   endtask

   task automatic t_reach_reg();
      fb_hi = 1'b1;
      step(2037);
      chk("R3 top of ramp", ref_code, 2047);
      chk("R9 pgood forced low in ramp", pgood, 0);
      step(1);
      chk("R8 pgood set in regulation", pgood, 1);
      step(20);
      chk("R3 holds full scale", ref_code, 2047);
      chk("R4 drv in regulation", drv_en, 1);
   endtask

   task automatic t_hyst();
      fb_hi = 1'b0; step(3);
      chk("R8 held in band", pgood, 1);
      fb_lo = 1'b1; step(1);
      chk("R8 cleared below", pgood, 0);
      fb_lo = 1'b0; step(2);
      chk("R8 stays low in band", pgood, 0);
      fb_hi = 1'b1; step(1);
      chk("R8 set again", pgood, 1);
   endtask

   task automatic t_ocp();
      ocp_flag = 1'b1; #1;
      chk("R6 drv off same cycle", drv_en, 0);
      step(1); ocp_flag = 1'b0;
      chk("R6 ref cleared", ref_code, 0);
      chk("R9 pgood low after ocp", pgood, 0);
      step(1000);
      chk("R9 pgood low in hiccup", pgood, 0);
      ocp_flag = 1'b1; step(1); ocp_flag = 1'b0;
      step(1046);
      chk("R6 still waiting", drv_en, 0);
      step(1);
      chk("R6 idle after wait", drv_en, 0);
      step(1);
      chk("R7 restart on time", drv_en, 1);
      chk("R6 restart from zero", ref_code, 0);
   endtask

   task automatic t_disable();
      step(5);
      chk("R3 ramp after restart", ref_code, 5);
      en_lo = 1'b1; #1;
      chk("R5 drv off same cycle", drv_en, 0);
      step(1); en_lo = 1'b0;
      chk("R5 ref cleared", ref_code, 0);
      step(5);
      chk("R5 stays off", drv_en, 0);
      en_hi = 1'b1; en_lo = 1'b1; step(1); en_hi = 1'b0; en_lo = 1'b0; step(2);
      chk("R2 lower flag wins", drv_en, 0);
      pulse_en_hi(); step(1);
      chk("R2 re-enable starts", drv_en, 1);
   endtask

   task automatic t_por();
      step(4);
      por_ok = 1'b0; #1;
      chk("R10 drv off same cycle", drv_en, 0);
      step(1);
      chk("R10 ref cleared", ref_code, 0);
      por_ok = 1'b1; step(1);
      chk("R10 restart", drv_en, 1);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sw_tick = 1'b1; por_ok = 1'b0; en_hi = 1'b0; en_lo = 1'b0;
      ocp_flag = 1'b0; fb_hi = 1'b0; fb_lo = 1'b0;
      step(3);
      t_reset();
      rst_n = 1'b1; step(1);
      t_reset();
      t_start_gate();
      t_tick_gate();
      t_reach_reg();
      t_hyst();
      t_ocp();
      t_disable();
      t_por();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule